// File: doc/BRIEF.md
# Serial Port Interrupt Identification

This block gathers the interrupt sources of a serial port's receive and transmit paths, ranks them and presents one byte that a host reads to learn which source needs service. It also drives an active-high interrupt request that is high whenever any source is pending. Four sources are ranked. Receiver line errors come first. Received data and a receive FIFO character time-out share the second level. The transmit holding register empty condition comes last.

Each source is cleared in its own way. The line error latch clears on a read of the line status register. Received data follows a level that the receive path supplies, so it drops when the buffer is read or the FIFO falls below its trigger. The time-out latch clears on a receive buffer read. The transmit-empty latch clears on a write to the holding register, or on a read of the identification byte while that byte is reporting transmit-empty. The time-out counter lives inside the block. It counts character-time ticks while the FIFO holds data and nothing is pushed or popped.

Top module: `uart_irq_ident`

## Requirements
- R1: `iir_byte[0]` is 0 exactly when a source is pending, and `irq` is its inverse.
- R2: Any bit of `line_err` (bit 0 overrun, 1 parity, 2 framing, 3 break) latches a line status source, reported as `iir_byte[3:0]` = 0110 ahead of all others. `rd_lsr` clears it. A new error in the same cycle as `rd_lsr` keeps it pending.
- R3: While `rx_ready` is high and no line error is pending, `iir_byte[3:0]` = 0100 in the same cycle.
- R4: In FIFO mode, with the FIFO non-empty, the TO_CHARS-th `char_tick` (default 4) after the last push, pop or buffer read sets a time-out source, reported as 1100. `rd_rbr` clears it.
- R5: When received data and time-out are both pending, the byte reports 0100.
- R6: A rising edge of `thr_empty` latches a transmit-empty source, reported as 0010 when nothing else is pending. `wr_thr` clears it. `rd_iir` clears it only while 0010 is being reported; a read during a higher-priority report leaves it pending.
- R7: `iir_byte[5:4]` are always 0, and `iir_byte[7:6]` both equal `fifo_en`.
- R8: With `fifo_en` low, `iir_byte[3]` is 0 and no time-out is ever reported, whatever the FIFO and tick inputs do.
- R9: A push, pop or buffer read restarts the time-out count, and the count stays at zero while the FIFO is empty.
- R10: A synchronous reset clears every latched source, so the byte reads 0x01 (0xC1 in FIFO mode when `rx_ready` is low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | FIFO mode enable |
| line_err | input | 4 | Line error event pulses: overrun, parity, framing, break |
| rx_ready | input | 1 | Received data available / FIFO at trigger level |
| fifo_nonempty | input | 1 | Receive FIFO holds at least one character |
| fifo_push | input | 1 | Character written into receive FIFO |
| fifo_pop | input | 1 | Character taken out of receive FIFO |
| char_tick | input | 1 | One pulse per character time |
| thr_empty | input | 1 | Transmit holding register empty status |
| rd_lsr | input | 1 | Host read of line status register |
| rd_rbr | input | 1 | Host read of receive buffer |
| rd_iir | input | 1 | Host read of identification byte |
| wr_thr | input | 1 | Host write of transmit holding register |
| iir_byte | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two clearing paths can meet a setting path in one cycle. A line error pulse can land together with a line status read, and the bench drives both strobes in the same vector and expects 0110 to remain. An identification read can arrive while transmit-empty is pending behind a line error. The bench issues that read in such a cycle, removes the line error, and expects 0010 to surface afterwards. A third case puts received data and a time-out in the same cycle, and the bench expects 0100.

// File: rtl/uart_irq_pkg.sv
// Shared types for the interrupt identification block.
// Assumes: identification codes are fixed by the host software contract.
package uart_irq_pkg;

    // Low nibble codes of the identification byte
    typedef enum logic [3:0] {
        ID_NONE    = 4'b0001,
        ID_LINE    = 4'b0110,
        ID_RXDATA  = 4'b0100,
        ID_TIMEOUT = 4'b1100,
        ID_TXEMPTY = 4'b0010
    } irq_id_e;

    // One flag per interrupt source, highest priority first
    typedef struct packed {
        logic line;
        logic rxdata;
        logic timeout;
        logic txempty;
    } irq_pend_t;

endpackage

// File: rtl/irq_line_latch.sv
// Sticky latch for receiver line error events.
// Assumes: err bits are one-cycle event pulses; a new event beats a clear.
module irq_line_latch #(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err,
    input  logic             clr,
    output logic             pend
);

    // Latch on any error, release on status read unless a new error arrives
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (|err)
            pend <= 1'b1;
        else if (clr)
            pend <= 1'b0;
    end

endmodule

// File: rtl/irq_char_timeout.sv
// Character time-out detector for the receive FIFO.
// Counts char ticks while the FIFO is non-empty and idle; latches a source
// on the TO_CHARS-th tick. Assumes fifo_nonempty reflects the FIFO level.
module irq_char_timeout #(
    parameter int TO_CHARS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_en,
    input  logic fifo_nonempty,
    input  logic fifo_push,
    input  logic fifo_pop,
    input  logic rd_rbr,
    input  logic char_tick,
    output logic pend
);

    localparam int CNT_W = $clog2(TO_CHARS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TO_CHARS - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(TO_CHARS);

    logic [CNT_W-1:0] cnt;
    logic             restart;
    logic             fire;

    // Any FIFO activity, an empty FIFO or non-FIFO mode holds the count at zero
    always_comb restart = fifo_push | fifo_pop | rd_rbr | ~fifo_nonempty | ~fifo_en;

    // The final tick of the window completes the time-out
    always_comb fire = ~restart & char_tick & (cnt == LAST);

    // Tick counter, saturating at the window length
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (char_tick && cnt != FULL)
            cnt <= cnt + 1'b1;
    end

    // Time-out source latch, cleared by buffer read or leaving FIFO mode
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (fire)
            pend <= 1'b1;
        else if (rd_rbr || !fifo_en)
            pend <= 1'b0;
    end

endmodule

// File: rtl/irq_txempty_latch.sv
// Transmit-empty source latch, armed on a rising edge of the empty status.
// Assumes: ack is high only when the identification read reports this source.
module irq_txempty_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_empty,
    input  logic wr_thr,
    input  logic ack,
    output logic pend
);

    logic empty_q;

    // Remember last empty status for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            empty_q <= 1'b0;
        else
            empty_q <= thr_empty;
    end

    // Set on rising edge, clear on write or acknowledged identification read
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (thr_empty && !empty_q)
            pend <= 1'b1;
        else if (wr_thr || ack)
            pend <= 1'b0;
    end

endmodule

// File: rtl/irq_id_encoder.sv
// Priority encoder that builds the identification byte from source flags.
// Assumes: timeout flag is already gated by FIFO mode.
module irq_id_encoder
    import uart_irq_pkg::*;
(
    input  irq_pend_t   pend,
    input  logic        fifo_en,
    output logic [7:0]  id_byte,
    output logic        sel_tx
);

    irq_id_e code;

    // Pick the highest ranked pending source
    always_comb begin
        if (pend.line)
            code = ID_LINE;
        else if (pend.rxdata)
            code = ID_RXDATA;
        else if (pend.timeout)
            code = ID_TIMEOUT;
        else if (pend.txempty)
            code = ID_TXEMPTY;
        else
            code = ID_NONE;
    end

    // Assemble the byte: mode bits, two zero bits, source code
    always_comb id_byte = {fifo_en, fifo_en, 2'b00, code};

    // Tell the transmit latch it is the reported source
    always_comb sel_tx = (code == ID_TXEMPTY);

endmodule

// File: rtl/uart_irq_ident.sv
// Top of the interrupt identification block: source latches plus encoder.
// Assumes: host strobes are single-cycle pulses synchronous to clk.
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int ERR_W    = 4,
    parameter int TO_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [ERR_W-1:0] line_err,
    input  logic             rx_ready,
    input  logic             fifo_nonempty,
    input  logic             fifo_push,
    input  logic             fifo_pop,
    input  logic             char_tick,
    input  logic             thr_empty,
    input  logic             rd_lsr,
    input  logic             rd_rbr,
    input  logic             rd_iir,
    input  logic             wr_thr,
    output logic [7:0]       iir_byte,
    output logic             irq
);

    irq_pend_t pend;
    logic      line_p;
    logic      to_p;
    logic      tx_p;
    logic      sel_tx;
    logic      tx_ack;

    irq_line_latch #(.ERR_W(ERR_W)) u_line (
        .clk  (clk),
        .rst_n(rst_n),
        .err  (line_err),
        .clr  (rd_lsr),
        .pend (line_p)
    );

    irq_char_timeout #(.TO_CHARS(TO_CHARS)) u_tmo (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_en      (fifo_en),
        .fifo_nonempty(fifo_nonempty),
        .fifo_push    (fifo_push),
        .fifo_pop     (fifo_pop),
        .rd_rbr       (rd_rbr),
        .char_tick    (char_tick),
        .pend         (to_p)
    );

    // Identification read acknowledges transmit-empty only when it is reported
    always_comb tx_ack = rd_iir & sel_tx;

    irq_txempty_latch u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .thr_empty(thr_empty),
        .wr_thr   (wr_thr),
        .ack      (tx_ack),
        .pend     (tx_p)
    );

    // Collect source flags; time-out only counts in FIFO mode
    always_comb begin
        pend.line    = line_p;
        pend.rxdata  = rx_ready;
        pend.timeout = to_p & fifo_en;
        pend.txempty = tx_p;
    end

    irq_id_encoder u_enc (
        .pend   (pend),
        .fifo_en(fifo_en),
        .id_byte(iir_byte),
        .sel_tx (sel_tx)
    );

    // Request line is high when any source is pending
    always_comb irq = |pend;

endmodule

// File: rtl/uart_irq_ident_chk.sv
// Property checker for the identification block, attached by bind.
module uart_irq_ident_chk #(
    parameter int ERR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic [ERR_W-1:0] line_err,
    input logic             rx_ready,
    input logic             thr_empty,
    input logic             wr_thr,
    input logic [7:0]       iir_byte,
    input logic             irq
);

    // R1: request line and pending bit disagree never
    a_r1_irq_matches: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ~iir_byte[0]);

    // R2: an error event is reported as line status next cycle
    a_r2_line_first: assert property (@(posedge clk) disable iff (!rst_n)
        (|line_err) |=> (iir_byte[3:0] == 4'b0110));

    // R5: received data hides a time-out
    a_r5_rx_over_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> (iir_byte[3:0] != 4'b1100));

    // R6: a holding register write without a new edge clears transmit-empty
    a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_thr && $stable(thr_empty)) |=> (iir_byte[3:0] != 4'b0010));

    // R7: fixed and mode bits
    a_r7_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_byte[5:4] == 2'b00) && (iir_byte[7:6] == {2{fifo_en}}));

    // R8: no time-out flag outside FIFO mode
    a_r8_no_bit3: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> !iir_byte[3]);

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.ERR_W(ERR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_en  (fifo_en),
    .line_err (line_err),
    .rx_ready (rx_ready),
    .thr_empty(thr_empty),
    .wr_thr   (wr_thr),
    .iir_byte (iir_byte),
    .irq      (irq)
);

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic [3:0] line_err = '0;
    logic       rx_ready = 1'b0;
    logic       fifo_nonempty = 1'b0;
    logic       fifo_push = 1'b0;
    logic       fifo_pop = 1'b0;
    logic       char_tick = 1'b0;
    logic       thr_empty = 1'b0;
    logic       rd_lsr = 1'b0;
    logic       rd_rbr = 1'b0;
    logic       rd_iir = 1'b0;
    logic       wr_thr = 1'b0;
    logic [7:0] iir_byte;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    uart_irq_ident dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .line_err(line_err),
        .rx_ready(rx_ready), .fifo_nonempty(fifo_nonempty),
        .fifo_push(fifo_push), .fifo_pop(fifo_pop), .char_tick(char_tick),
        .thr_empty(thr_empty), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr),
        .rd_iir(rd_iir), .wr_thr(wr_thr), .iir_byte(iir_byte), .irq(irq)
    );

    // Vector: {fifo_en, line_err[3:0], rx_ready, thr_empty, rd_lsr, rd_iir, wr_thr, expected}
    localparam int NV = 19;
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01}, // R1 idle
        {1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h02}, // R6 edge arms
        {1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h04}, // R3 over tx
        {1'b0, 4'h1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h06}, // R2 overrun
        {1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h06}, // R6 read while line shown
        {1'b0, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h04}, // R2 lsr read clears
        {1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h02}, // R6 survived read
        {1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h01}, // R6 read acks
        {1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01}, // R6 fall no set
        {1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h02}, // R6 re-armed
        {1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h01}, // R6 write clears
        {1'b0, 4'h4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h06}, // R2 framing
        {1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h01}, // R2 cleared
        {1'b1, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hC1}, // R7 fifo bits
        {1'b1, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hC4}, // R3 fifo trigger
        {1'b1, 4'h8, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hC6}, // R2 break with read
        {1'b1, 4'h2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hC6}, // R2 parity
        {1'b1, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hC4}, // R2 read clears
        {1'b1, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hC1}  // R3 level drops
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: iir_byte=%02h expected %02h", tag, act, exp);
        end
        checks++;
        if (irq !== ~exp[0]) begin
            fails++;
            $display("FAIL R1 (%s): irq=%b expected %b", tag, irq, ~exp[0]);
        end
    endtask

    // One clock with strobes held, then strobes released before sampling
    task automatic cycle();
        @(posedge clk);
        #1;
        line_err = '0; rd_lsr = 0; rd_rbr = 0; rd_iir = 0; wr_thr = 0;
        fifo_push = 0; fifo_pop = 0; char_tick = 0;
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            char_tick = 1'b1;
            cycle();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset state", iir_byte, 8'h01);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            {fifo_en, line_err, rx_ready, thr_empty, rd_lsr, rd_iir, wr_thr} = VEC[i][17:8];
            cycle();
            check($sformatf("vector %0d", i), iir_byte, VEC[i][7:0]);
        end

        // R4: time-out after four idle ticks, FIFO mode, tx source cleared first
        wr_thr = 1'b1; cycle();
        fifo_nonempty = 1'b1; fifo_push = 1'b1; cycle();
        ticks(3);
        check("R4 three ticks no timeout", iir_byte, 8'hC1);
        ticks(1);
        check("R4 timeout reported", iir_byte, 8'hCC);
        rx_ready = 1'b1; #1;
        check("R5 rx data over timeout", iir_byte, 8'hC4);
        rx_ready = 1'b0; #1;
        check("R4 timeout still pending", iir_byte, 8'hCC);
        rd_rbr = 1'b1; cycle();
        check("R4 buffer read clears", iir_byte, 8'hC1);

        // R9: push restarts the count
        ticks(3);
        fifo_push = 1'b1; cycle();
        ticks(3);
        check("R9 push restarts count", iir_byte, 8'hC1);
        fifo_pop = 1'b1; cycle();
        ticks(3);
        check("R9 pop restarts count", iir_byte, 8'hC1);
        ticks(1);
        check("R9 fires after pop window", iir_byte, 8'hCC);
        rd_rbr = 1'b1; cycle();

        // R9: empty FIFO holds count at zero
        fifo_nonempty = 1'b0;
        ticks(6);
        check("R9 empty fifo no timeout", iir_byte, 8'hC1);

        // R8: non-FIFO mode ignores ticks
        fifo_en = 1'b0; fifo_nonempty = 1'b1; fifo_push = 1'b1; cycle();
        ticks(6);
        check("R8 no timeout outside fifo mode", iir_byte, 8'h01);

        // R10: reset clears a latched line error
        fifo_en = 1'b1; line_err = 4'h1; cycle();
        check("R2 set before reset", iir_byte, 8'hC6);
        rst_n = 1'b0; cycle();
        rst_n = 1'b1; #1;
        check("R10 reset clears sources", iir_byte, 8'hC1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule